// File: doc/BRIEF.md
# Burst Column Sequencer with Read-Latency Pipeline

This block is the burst engine of a synchronous DRAM column path. A read or write command arrives together with a starting column. The block then presents one column address per clock for each beat of the burst. The number of beats comes from the programmed burst length. The order of the beats is either a wrapping count or an XOR pattern, kept inside an aligned block of the burst's size. A full-page burst walks the whole column space and keeps going until it is stopped.

For reads, a data-valid strobe follows each read column after the programmed latency of two or three clocks. A terminate command or a new command can end a burst on any cycle. Read beats that were already issued still produce their data-valid strobes. In single-write mode, every write is a single beat, while reads keep their programmed length.

The block sits in a memory model or in a controller's shadow of the device state. Its outputs cannot be stalled, so it has no back-pressure. A consumer must take every column and data-valid strobe in the cycle it is shown. A command is accepted in the cycle it is sampled, with no handshake. The mode inputs are captured with each command.

Top module: `burst_col_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `col_valid`, `wr_beat_valid`, `rd_data_valid` and `burst_done` are low.
- R2: A command sampled at a clock edge (`cmd_rd` or `cmd_wr`) puts its first beat on the outputs right after that edge, with `col` equal to `start_col`. Later beats follow on consecutive cycles. `col_is_read` is 1 for reads, and `wr_beat_valid` is high exactly on write beats.
- R3: The burst length code `mode_len` maps as follows: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives a full page. The codes 100, 101 and 110 give 1 beat. `burst_done` is high together with the final beat of a burst that ends by itself.
- R4: In wrapping order (`mode_xor`=0), the low log2(L) bits of the column equal (start + beat index) mod L, and the upper bits stay those of the start column.
- R5: In XOR order (`mode_xor`=1), the low log2(L) bits of the column equal the start column's low bits XOR the beat index. The upper bits are unchanged.
- R6: A full-page burst presents start, start+1, … modulo 256 without end and never raises `burst_done`. `mode_xor` is ignored for full-page bursts.
- R7: `rd_data_valid` is high exactly 2 cycles (`mode_lat3`=0) or 3 cycles (`mode_lat3`=1) after each cycle that shows a read beat, and at no other time.
- R8: `cmd_term` alone stops the burst: no beat is shown after that edge. Read beats shown before it still raise `rd_data_valid`.
- R9: A command sampled during a burst replaces that burst at once, on any beat. When several commands are sampled together, read beats write and both beat terminate.
- R10: With `mode_single_wr`=1, a write presents one beat with `burst_done`. Reads keep their programmed length.
- R11: The mode inputs and `start_col` are captured with the command. Changing them during a burst does not change that burst's columns, length or read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_rd | input | 1 | Read command strobe |
| cmd_wr | input | 1 | Write command strobe |
| cmd_term | input | 1 | Burst terminate strobe |
| start_col | input | COL_W | Starting column of the command |
| mode_len | input | 3 | Burst length code |
| mode_xor | input | 1 | 1 selects XOR beat order |
| mode_lat3 | input | 1 | 1 selects read latency 3, 0 selects 2 |
| mode_single_wr | input | 1 | 1 makes every write a single beat |
| col_valid | output | 1 | A beat column is shown this cycle |
| col | output | COL_W | Column of the current beat |
| col_is_read | output | 1 | The current beat belongs to a read |
| wr_beat_valid | output | 1 | Write data beat expected this cycle |
| rd_data_valid | output | 1 | Read data beat delivered this cycle |
| burst_done | output | 1 | The current beat is the last of its burst |

## Verification
The assertions watch several rules on every cycle. A command's first beat must carry the start column. A lone terminate must empty the column stream. `burst_done` must end the stream. Single-write bursts must be one beat long. Each read beat must be paired with a data-valid strobe at its captured latency, in both directions. The bench scenarios cover what only a known stimulus can show. These are the exact column orders of both orderings at every length, including wrap across the upper end of the column space. They also include the endless full page, interruption in mid-burst, and the command priority. Last, they show that mode changes during a burst leave it untouched.

// File: rtl/bce_pkg.sv
package bce_pkg;
  // Burst length codes; any other value selects a single beat.
  localparam logic [2:0] LEN_1    = 3'b000;
  localparam logic [2:0] LEN_2    = 3'b001;
  localparam logic [2:0] LEN_4    = 3'b010;
  localparam logic [2:0] LEN_8    = 3'b011;
  localparam logic [2:0] LEN_PAGE = 3'b111;

  // Attributes of the burst in flight, captured with its command.
  typedef struct packed {
    logic is_rd;
    logic xor_ord;
    logic page;
    logic lat3;
  } burst_attr_t;
endpackage

// File: rtl/bce_mode_dec.sv
module bce_mode_dec
  import bce_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [2:0]       len_code,
  input  logic             xor_req,
  input  logic             single_wr,
  input  logic             is_write,
  output logic [COL_W-1:0] wrap_mask,
  output logic             page,
  output logic             xor_eff
);
  logic [COL_W-1:0] mask_raw;
  logic             page_raw;

  always_comb begin
    mask_raw = '0;
    page_raw = 1'b0;
    case (len_code)
      LEN_2:    mask_raw = COL_W'(1);
      LEN_4:    mask_raw = COL_W'(3);
      LEN_8:    mask_raw = COL_W'(7);
      LEN_PAGE: begin
        mask_raw = '1;
        page_raw = 1'b1;
      end
      default:  mask_raw = '0;
    endcase
  end

  // A write in single-write mode always collapses to one beat.
  assign wrap_mask = (is_write && single_wr) ? '0 : mask_raw;
  assign page      = (is_write && single_wr) ? 1'b0 : page_raw;
  // A full page always counts upward.
  assign xor_eff   = xor_req && !page;
endmodule

// File: rtl/bce_col_gen.sv
module bce_col_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [COL_W-1:0] beat_idx,
  input  logic [COL_W-1:0] wrap_mask,
  input  logic             xor_ord,
  output logic [COL_W-1:0] beat_col
);
  logic [COL_W-1:0] sum_col;
  logic [COL_W-1:0] mix_col;

  assign sum_col = base_col + beat_idx;
  assign mix_col = base_col ^ beat_idx;

  // The mask is contiguous from bit 0. Bits inside it take the ordered value.
  // Bits above it keep the start column, which also drops the carry out of
  // the wrapped field.
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign beat_col[b] = wrap_mask[b] ? (xor_ord ? mix_col[b] : sum_col[b])
                                      : base_col[b];
  end
endmodule

// File: rtl/bce_burst_ctrl.sv
module bce_burst_ctrl
  import bce_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             stop,
  input  logic [COL_W-1:0] load_col,
  input  logic [COL_W-1:0] load_mask,
  input  burst_attr_t      load_attr,
  output logic             active,
  output logic             last_beat,
  output logic [COL_W-1:0] base_col,
  output logic [COL_W-1:0] beat_idx,
  output logic [COL_W-1:0] wrap_mask,
  output burst_attr_t      attr
);
  assign last_beat = active && !attr.page && (beat_idx == wrap_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      beat_idx  <= '0;
      base_col  <= '0;
      wrap_mask <= '0;
      attr      <= '0;
    end else if (go) begin
      active    <= 1'b1;
      beat_idx  <= '0;
      base_col  <= load_col;
      wrap_mask <= load_mask;
      attr      <= load_attr;
    end else if (stop) begin
      active    <= 1'b0;
    end else if (active) begin
      if (last_beat) active <= 1'b0;
      beat_idx <= beat_idx + COL_W'(1);
    end
  end
endmodule

// File: rtl/bce_lat_pipe.sv
module bce_lat_pipe #(
  parameter int MAX_LAT = 3,
  parameter int LAT_W   = $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_in,
  input  logic [LAT_W-1:0] lat,
  output logic             beat_out
);
  // A beat enters at stage MAX_LAT-lat, one edge after it is shown, so it
  // leaves the last stage exactly lat cycles after it was shown.
  logic [MAX_LAT-1:0] stage;
  logic [LAT_W-1:0]   entry;

  assign entry = LAT_W'(MAX_LAT) - lat;

  for (genvar j = 0; j < MAX_LAT; j++) begin : g_stage
    logic from_prev;
    if (j == 0) begin : g_head
      assign from_prev = 1'b0;
    end else begin : g_body
      assign from_prev = stage[j-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) stage[j] <= 1'b0;
      else        stage[j] <= from_prev | (beat_in && (entry == LAT_W'(j)));
    end
  end

  assign beat_out = stage[MAX_LAT-1];
endmodule

// File: rtl/burst_col_engine.sv
module burst_col_engine
  import bce_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int LAT_LO = 2,
  parameter int LAT_HI = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic             cmd_term,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       mode_len,
  input  logic             mode_xor,
  input  logic             mode_lat3,
  input  logic             mode_single_wr,
  output logic             col_valid,
  output logic [COL_W-1:0] col,
  output logic             col_is_read,
  output logic             wr_beat_valid,
  output logic             rd_data_valid,
  output logic             burst_done
);
  localparam int LAT_W = $clog2(LAT_HI + 1);

  logic             go;
  logic             is_wr_cmd;
  logic [COL_W-1:0] dec_mask;
  logic             dec_page;
  logic             dec_xor;
  burst_attr_t      new_attr;

  logic             active;
  logic             last_beat;
  logic [COL_W-1:0] base_col;
  logic [COL_W-1:0] beat_idx;
  logic [COL_W-1:0] wrap_mask;
  burst_attr_t      attr;
  logic [LAT_W-1:0] lat_sel;

  // A read wins over a write; either one wins over a terminate.
  assign go        = cmd_rd || cmd_wr;
  assign is_wr_cmd = cmd_wr && !cmd_rd;

  bce_mode_dec #(.COL_W(COL_W)) u_dec (
    .len_code  (mode_len),
    .xor_req   (mode_xor),
    .single_wr (mode_single_wr),
    .is_write  (is_wr_cmd),
    .wrap_mask (dec_mask),
    .page      (dec_page),
    .xor_eff   (dec_xor)
  );

  always_comb begin
    new_attr.is_rd   = cmd_rd;
    new_attr.xor_ord = dec_xor;
    new_attr.page    = dec_page;
    new_attr.lat3    = mode_lat3;
  end

  bce_burst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .stop      (cmd_term),
    .load_col  (start_col),
    .load_mask (dec_mask),
    .load_attr (new_attr),
    .active    (active),
    .last_beat (last_beat),
    .base_col  (base_col),
    .beat_idx  (beat_idx),
    .wrap_mask (wrap_mask),
    .attr      (attr)
  );

  bce_col_gen #(.COL_W(COL_W)) u_col (
    .base_col  (base_col),
    .beat_idx  (beat_idx),
    .wrap_mask (wrap_mask),
    .xor_ord   (attr.xor_ord),
    .beat_col  (col)
  );

  assign lat_sel = attr.lat3 ? LAT_W'(LAT_HI) : LAT_W'(LAT_LO);

  bce_lat_pipe #(.MAX_LAT(LAT_HI), .LAT_W(LAT_W)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_in  (active && attr.is_rd),
    .lat      (lat_sel),
    .beat_out (rd_data_valid)
  );

  assign col_valid     = active;
  assign col_is_read   = active && attr.is_rd;
  assign wr_beat_valid = active && !attr.is_rd;
  assign burst_done    = last_beat;
endmodule

// File: rtl/bce_checker.sv
module bce_checker #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_rd,
  input logic             cmd_wr,
  input logic             cmd_term,
  input logic [COL_W-1:0] start_col,
  input logic             mode_single_wr,
  input logic             col_valid,
  input logic [COL_W-1:0] col,
  input logic             col_is_read,
  input logic             wr_beat_valid,
  input logic             rd_data_valid,
  input logic             burst_done,
  input logic             lat3_q
);
  AST_FIRST_BEAT_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd || cmd_wr) |=> (col_valid && col == $past(start_col))); // R2

  AST_READ_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd |=> col_is_read); // R9

  AST_WR_BEAT_ONLY_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_beat_valid |-> (col_valid && !col_is_read)); // R2

  AST_TERM_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_term && !cmd_rd && !cmd_wr) |=> !col_valid); // R8

  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && !cmd_rd && !cmd_wr) |=> !col_valid); // R3

  AST_DONE_WITH_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> col_valid); // R3

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_rd && mode_single_wr) |=> burst_done); // R10

  AST_RDV_LAT2: assert property (@(posedge clk) disable iff (!rst_n)
    (col_is_read && !lat3_q) |=> ##1 rd_data_valid); // R7

  AST_RDV_LAT3: assert property (@(posedge clk) disable iff (!rst_n)
    (col_is_read && lat3_q) |=> ##2 rd_data_valid); // R7

  AST_RDV_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_valid |-> ($past(col_is_read && !lat3_q, 2) ||
                       $past(col_is_read && lat3_q, 3))); // R7
endmodule

bind burst_col_engine bce_checker #(.COL_W(COL_W)) u_bce_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_rd         (cmd_rd),
  .cmd_wr         (cmd_wr),
  .cmd_term       (cmd_term),
  .start_col      (start_col),
  .mode_single_wr (mode_single_wr),
  .col_valid      (col_valid),
  .col            (col),
  .col_is_read    (col_is_read),
  .wr_beat_valid  (wr_beat_valid),
  .rd_data_valid  (rd_data_valid),
  .burst_done     (burst_done),
  .lat3_q         (attr.lat3)
);

// File: tb/burst_col_engine_tb_top.sv
module burst_col_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  typedef struct packed {
    logic       rd;
    logic       xo;
    logic [2:0] len;
    logic [7:0] col;
    logic       lat3;
    logic       sw;
  } vec_t;

  // Stimulus table; expected beats are computed from the requirements.
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 3'b010, 8'h0E, 1'b0, 1'b0},  // R4 wrap inside 4
    '{1'b1, 1'b1, 3'b011, 8'h35, 1'b1, 1'b0},  // R5 xor 8
    '{1'b0, 1'b0, 3'b011, 8'hFD, 1'b0, 1'b0},  // R4 write 8 at top
    '{1'b1, 1'b0, 3'b000, 8'h42, 1'b1, 1'b0},  // R3 length 1
    '{1'b0, 1'b0, 3'b011, 8'h10, 1'b0, 1'b1},  // R10 single write
    '{1'b1, 1'b0, 3'b001, 8'h07, 1'b0, 1'b0},  // R4 length 2
    '{1'b1, 1'b1, 3'b010, 8'h9B, 1'b0, 1'b1},  // R10 read unaffected, R5
    '{1'b0, 1'b0, 3'b100, 8'h20, 1'b0, 1'b0}   // R3 reserved code
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_rd = 1'b0, cmd_wr = 1'b0, cmd_term = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] mode_len = '0;
  logic       mode_xor = 1'b0, mode_lat3 = 1'b0, mode_single_wr = 1'b0;
  logic       col_valid, col_is_read, wr_beat_valid, rd_data_valid, burst_done;
  logic [7:0] col;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .cmd_term(cmd_term), .start_col(start_col), .mode_len(mode_len),
    .mode_xor(mode_xor), .mode_lat3(mode_lat3),
    .mode_single_wr(mode_single_wr), .col_valid(col_valid), .col(col),
    .col_is_read(col_is_read), .wr_beat_valid(wr_beat_valid),
    .rd_data_valid(rd_data_valid), .burst_done(burst_done)
  );

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int len_of(input logic [2:0] code, input bit wr, input bit sw);
    if (wr && sw) return 1;
    case (code)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 256;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(input int s, input int k, input int len, input bit xo);
    int m, lo;
    m  = len - 1;
    lo = xo ? ((s ^ k) & m) : ((s + k) & m);
    return ((s & ~m) | lo) & 8'hFF;
  endfunction

  task automatic idle_cmds();
    cmd_rd = 1'b0; cmd_wr = 1'b0; cmd_term = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input int n);
    int len, lat, rdv;
    len = len_of(v.len, !v.rd, v.sw);
    lat = v.lat3 ? 3 : 2;
    @(negedge clk);
    cmd_rd = v.rd; cmd_wr = !v.rd; start_col = v.col; mode_len = v.len;
    mode_xor = v.xo; mode_lat3 = v.lat3; mode_single_wr = v.sw;
    for (int t = 0; t < len + 5; t++) begin
      @(negedge clk);
      if (t == 0) idle_cmds();
      chk("R2", $sformatf("vec%0d t%0d col_valid", n, t), col_valid, t < len);
      if (t < len) begin
        chk(v.xo ? "R5" : "R4", $sformatf("vec%0d t%0d col", n, t), col,
            exp_col(v.col, t, len, v.xo));
        chk("R2", $sformatf("vec%0d t%0d col_is_read", n, t), col_is_read, v.rd);
        chk("R2", $sformatf("vec%0d t%0d wr_beat_valid", n, t), wr_beat_valid, !v.rd);
        chk(v.sw ? "R10" : "R3", $sformatf("vec%0d t%0d burst_done", n, t),
            burst_done, t == len - 1);
      end
      rdv = (v.rd && t >= lat && t < lat + len) ? 1 : 0;
      chk("R7", $sformatf("vec%0d t%0d rd_data_valid", n, t), rd_data_valid, rdv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", "col_valid in reset", col_valid, 0);
    chk("R1", "rd_data_valid in reset", rd_data_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "col_valid after reset", col_valid, 0);
    chk("R1", "wr_beat_valid after reset", wr_beat_valid, 0);
    chk("R1", "burst_done after reset", burst_done, 0);
    chk("R1", "rd_data_valid after reset", rd_data_valid, 0);

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);

    // R6 full page with xor request ignored, then R8 terminate
    @(negedge clk);
    cmd_rd = 1'b1; start_col = 8'hFE; mode_len = 3'b111; mode_xor = 1'b1;
    mode_lat3 = 1'b0; mode_single_wr = 1'b0;
    for (int t = 0; t < 260; t++) begin
      @(negedge clk);
      if (t == 0) idle_cmds();
      chk("R6", $sformatf("page t%0d col", t), col, (8'hFE + t) & 8'hFF);
      chk("R6", $sformatf("page t%0d done", t), burst_done, 0);
      chk("R6", $sformatf("page t%0d valid", t), col_valid, 1);
      if (t == 259) cmd_term = 1'b1;
    end
    @(negedge clk); idle_cmds();
    chk("R8", "term col_valid", col_valid, 0);
    chk("R8", "term in-flight rdv 1", rd_data_valid, 1);
    @(negedge clk);
    chk("R8", "term in-flight rdv 2", rd_data_valid, 1);
    @(negedge clk);
    chk("R8", "term pipe drained", rd_data_valid, 0);

    // R9 interruption of a read by a write after three beats
    @(negedge clk);
    cmd_rd = 1'b1; start_col = 8'h00; mode_len = 3'b011; mode_xor = 1'b0;
    mode_lat3 = 1'b1;
    for (int t = 0; t < 9; t++) begin
      @(negedge clk);
      if (t == 0) idle_cmds();
      if (t < 3) chk("R9", $sformatf("intr t%0d rd col", t), col, t);
      if (t >= 3 && t < 7) begin
        chk("R9", $sformatf("intr t%0d wr col", t), col, 8'h50 + t - 3);
        chk("R9", $sformatf("intr t%0d is_read", t), col_is_read, 0);
        chk("R9", $sformatf("intr t%0d done", t), burst_done, t == 6);
      end
      if (t == 7) chk("R9", "intr end", col_valid, 0);
      chk("R8", $sformatf("intr t%0d rdv", t), rd_data_valid, (t >= 3 && t <= 5) ? 1 : 0);
      if (t == 2) begin
        cmd_wr = 1'b1; start_col = 8'h50; mode_len = 3'b010;
      end
      if (t == 3) idle_cmds();
    end

    // R9 priority: read over write over terminate
    @(negedge clk);
    cmd_rd = 1'b1; cmd_wr = 1'b1; cmd_term = 1'b1; start_col = 8'h11;
    mode_len = 3'b001; mode_lat3 = 1'b0;
    @(negedge clk); idle_cmds();
    chk("R9", "prio all valid", col_valid, 1);
    chk("R9", "prio all read", col_is_read, 1);
    chk("R9", "prio all col", col, 8'h11);
    cmd_wr = 1'b1; cmd_term = 1'b1; start_col = 8'h60;
    @(negedge clk); idle_cmds();
    chk("R9", "prio wr valid", col_valid, 1);
    chk("R9", "prio wr kind", wr_beat_valid, 1);
    chk("R9", "prio wr col", col, 8'h60);
    repeat (5) @(negedge clk);

    // R11 mode changes during a burst have no effect on it
    cmd_rd = 1'b1; start_col = 8'h23; mode_len = 3'b011; mode_xor = 1'b0;
    mode_lat3 = 1'b0;
    for (int t = 0; t < 11; t++) begin
      @(negedge clk);
      if (t == 0) begin
        idle_cmds();
        mode_len = 3'b000; mode_xor = 1'b1; start_col = 8'hFF; mode_lat3 = 1'b1;
      end
      chk("R11", $sformatf("cap t%0d valid", t), col_valid, t < 8);
      if (t < 8) begin
        chk("R11", $sformatf("cap t%0d col", t), col, exp_col(8'h23, t, 8, 1'b0));
        chk("R11", $sformatf("cap t%0d done", t), burst_done, t == 7);
      end
      chk("R11", $sformatf("cap t%0d rdv", t), rd_data_valid, (t >= 2 && t < 10) ? 1 : 0);
    end

    // R8 terminate with nothing active leaves outputs idle
    cmd_term = 1'b1;
    @(negedge clk); idle_cmds();
    chk("R8", "idle term col_valid", col_valid, 0);
    chk("R8", "idle term rdv", rd_data_valid, 0);

    finish_run();
  end
endmodule